// File: doc/BRIEF.md
# Two-Channel Serial Wiper Code Loader

This block is the control front end of a dual, 256-step digital potentiometer. A host writes to it over a three-wire serial bus: a serial clock, a serial data line and an active-low select. Each write frame carries one channel-select bit and an 8-bit wiper code. When the frame closes, the code goes into the wiper register of the selected channel. The register outputs drive the resistor network directly.

All three bus pins are asynchronous to the system clock. Each passes through a synchronizer of configurable depth, and the serial clock edges are detected in the system clock domain. A frame is accepted only if at least nine serial clock rising edges arrive while select is low. In a frame longer than nine bits, the nine most recent bits are the ones used.

There is no back-pressure. An accepted frame always updates its channel, and a one-cycle load pulse marks the update. The bus has no valid/ready handshake because the serial protocol has no way to stall the host. The host must space its frames by at least the synchronizer latency plus three system clocks.

Top module: `wiper_loader`

## Requirements
- R1: After reset, both wiper outputs hold the midscale code 0x80 and both load pulses are low.
- R2: A frame is nine bits shifted in most-significant first on serial clock rising edges. The first bit of the nine is the channel select and the remaining eight are the wiper code, most-significant bit first.
- R3: A select bit of 0 writes `wiper_a` and a select bit of 1 writes `wiper_b`. The other channel keeps its value.
- R4: A wiper output changes only after `spi_csn` rises. While `spi_csn` stays low, the outputs hold their values even after nine or more bits have been shifted in.
- R5: Serial clock edges that occur while `spi_csn` is high shift nothing and update nothing.
- R6: If a frame has more than nine serial clock edges, the earlier bits are dropped and the last nine received are decoded. The bit counter saturates at nine.
- R7: A frame that closes with fewer than nine serial clock edges is discarded, and neither wiper changes.
- R8: Each accepted frame produces exactly one single-cycle pulse on the load output of the written channel. The pulse occurs in the same cycle that the new code first appears, and a wiper never changes without its pulse.
- R9: The two load outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, asynchronous |
| spi_sdi | input | 1 | Serial data from host, asynchronous |
| spi_csn | input | 1 | Active-low frame select, asynchronous |
| wiper_a | output | 8 | Wiper code, channel A |
| wiper_b | output | 8 | Wiper code, channel B |
| load_a | output | 1 | One-cycle pulse when wiper_a is written |
| load_b | output | 1 | One-cycle pulse when wiper_b is written |

## Verification
The hardest case to reach is the boundary of the bit counter. A frame must stop exactly one edge short of nine, or run past nine so the counter saturates and the oldest bits fall out, and the result then has to be told apart from a correct nine-bit frame. The stimulus sends eight-bit and twelve-bit frames whose dropped bits hold a different channel select and code than the retained bits. A misaligned window then lands on a visibly wrong channel or value. A further frame holds select low after nine bits, so the bench can confirm that nothing is committed before select rises.

// File: rtl/wiper_loader_pkg.sv
package wiper_loader_pkg;
  localparam int WORD_BITS = 9;
  localparam int CODE_W    = 8;
  localparam int NUM_CH    = 2;
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CNT_W     = $clog2(WORD_BITS + 1);

  typedef struct packed {
    logic [CH_W-1:0]   ch;
    logic [CODE_W-1:0] code;
  } wl_word_t;
endpackage

// File: rtl/wl_sync.sv
module wl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/wl_frame_rx.sv
module wl_frame_rx
  import wiper_loader_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     sdi_s,
  input  logic     csn_s,
  output logic     word_vld,
  output wl_word_t word
);
  logic                 sclk_d, csn_d;
  logic                 sclk_rise, cs_rise;
  logic [WORD_BITS-1:0] shift_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 full;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = csn_s & ~csn_d;
  assign full      = (cnt_q == CNT_W'(WORD_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  shift_q <= '0;
    else if (!csn_s && sclk_rise) shift_q <= {shift_q[WORD_BITS-2:0], sdi_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (csn_s)              cnt_q <= '0;
    else if (sclk_rise && !full) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      word_vld <= cs_rise && full;
      if (cs_rise) word <= wl_word_t'(shift_q);
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_BITS)); // R6
  AST_NO_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> $stable(shift_q)); // R5
  AST_VALID_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> ($past(csn_s) && !$past(csn_d))); // R4
endmodule

// File: rtl/wl_wiper_bank.sv
module wl_wiper_bank
  import wiper_loader_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_CODE = 8'h80
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           word_vld,
  input  wl_word_t                       word,
  output logic [NUM_CH-1:0][CODE_W-1:0]  wiper,
  output logic [NUM_CH-1:0]              load
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    assign hit = word_vld && (word.ch == CH_W'(ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper[ch] <= RESET_CODE;
        load[ch]  <= 1'b0;
      end else begin
        load[ch] <= hit;
        if (hit) wiper[ch] <= word.code;
      end
    end

    AST_CHANGE_HAS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper[ch] != $past(wiper[ch])) |-> load[ch]); // R8
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      load[ch] |=> !load[ch]); // R8
  end

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load)); // R9
endmodule

// File: rtl/wiper_loader.sv
module wiper_loader
  import wiper_loader_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] RESET_CODE  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  input  logic              spi_csn,
  output logic [CODE_W-1:0] wiper_a,
  output logic [CODE_W-1:0] wiper_b,
  output logic              load_a,
  output logic              load_b
);
  logic                          sclk_s, sdi_s, csn_s;
  logic                          word_vld;
  wl_word_t                      word;
  logic [NUM_CH-1:0][CODE_W-1:0] wiper;
  logic [NUM_CH-1:0]             load;

  wl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d_in(spi_sclk), .q_out(sclk_s));
  wl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d_in(spi_sdi), .q_out(sdi_s));
  wl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
    .clk(clk), .rst_n(rst_n), .d_in(spi_csn), .q_out(csn_s));

  wl_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdi_s(sdi_s), .csn_s(csn_s),
    .word_vld(word_vld), .word(word));

  wl_wiper_bank #(.RESET_CODE(RESET_CODE)) u_bank (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
    .wiper(wiper), .load(load));

  assign wiper_a = wiper[0];
  assign wiper_b = wiper[1];
  assign load_a  = load[0];
  assign load_b  = load[1];

  AST_RESET_MIDSCALE: assert property (@(posedge clk)
    !rst_n |=> (wiper_a == RESET_CODE && wiper_b == RESET_CODE)); // R1
endmodule

// File: tb/wiper_loader_tb.sv
module wiper_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0, spi_sdi = 1'b0, spi_csn = 1'b1;
  logic [7:0] wiper_a, wiper_b;
  logic       load_a, load_b;

  int n_tests = 0, n_fail = 0;
  int cnt_la = 0, cnt_lb = 0, silent_change = 0, both_high = 0;
  logic [7:0] last_a = 8'h80, last_b = 8'h80;

  always #5 clk = ~clk;

  wiper_loader u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi),
    .spi_csn(spi_csn), .wiper_a(wiper_a), .wiper_b(wiper_b),
    .load_a(load_a), .load_b(load_b));

  always @(negedge clk) if (rst_n) begin
    if (load_a) cnt_la++;
    if (load_b) cnt_lb++;
    if (load_a && load_b) both_high++;
    if ((wiper_a != last_a && !load_a) || (wiper_b != last_b && !load_b)) silent_change++;
    last_a = wiper_a;
    last_b = wiper_b;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input int nbits, input logic [15:0] bits);
    for (int i = nbits - 1; i >= 0; i--) begin
      spi_sdi = bits[i];
      wait_clk(4);
      spi_sclk = 1'b1;
      wait_clk(4);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame(input int nbits, input logic [15:0] bits);
    spi_csn = 1'b0;
    wait_clk(4);
    shift_bits(nbits, bits);
    wait_clk(4);
    spi_csn = 1'b1;
    wait_clk(12);
  endtask

  task automatic t_reset;
    check("R1 wiper_a", wiper_a, 8'h80);
    check("R1 wiper_b", wiper_b, 8'h80);
    check("R1 loads", {load_a, load_b}, 0);
  endtask

  task automatic t_write_a;
    int la = cnt_la, lb = cnt_lb;
    frame(9, {7'd0, 1'b0, 8'h3C});
    check("R2 wiper_a code", wiper_a, 8'h3C);
    check("R3 wiper_b held", wiper_b, 8'h80);
    check("R8 load_a count", cnt_la - la, 1);
    check("R8 load_b none", cnt_lb - lb, 0);
  endtask

  task automatic t_write_b;
    int lb = cnt_lb;
    frame(9, {7'd0, 1'b1, 8'hA5});
    check("R3 wiper_b code", wiper_b, 8'hA5);
    check("R3 wiper_a held", wiper_a, 8'h3C);
    check("R8 load_b count", cnt_lb - lb, 1);
  endtask

  task automatic t_hold_until_cs;
    spi_csn = 1'b0;
    wait_clk(4);
    shift_bits(9, {7'd0, 1'b0, 8'hF1});
    wait_clk(20);
    check("R4 wiper_a before cs rise", wiper_a, 8'h3C);
    spi_csn = 1'b1;
    wait_clk(12);
    check("R4 wiper_a after cs rise", wiper_a, 8'hF1);
  endtask

  task automatic t_deselected_clocks;
    int la = cnt_la, lb = cnt_lb;
    shift_bits(9, {7'd0, 1'b1, 8'h00});
    wait_clk(12);
    check("R5 wiper_b unchanged", wiper_b, 8'hA5);
    check("R5 no loads", (cnt_la - la) + (cnt_lb - lb), 0);
    frame(9, {7'd0, 1'b1, 8'h5A});
    check("R5 next frame clean", wiper_b, 8'h5A);
  endtask

  task automatic t_long_frame;
    // 12 bits: leading 3 bits 0,1,1 dropped; last nine are ch=0, code 0x96
    frame(12, {4'd0, 3'b011, 1'b0, 8'h96});
    check("R6 wiper_a last nine", wiper_a, 8'h96);
    check("R6 wiper_b untouched", wiper_b, 8'h5A);
  endtask

  task automatic t_short_frame;
    int la = cnt_la, lb = cnt_lb;
    frame(8, {8'd0, 8'h1F});
    check("R7 wiper_a unchanged", wiper_a, 8'h96);
    check("R7 wiper_b unchanged", wiper_b, 8'h5A);
    check("R7 no loads", (cnt_la - la) + (cnt_lb - lb), 0);
    frame(9, {7'd0, 1'b1, 8'hFF});
    check("R7 recover after short", wiper_b, 8'hFF);
  endtask

  initial begin : watchdog
    #1_500_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_write_a();
    t_write_b();
    t_hold_until_cs();
    t_deselected_clocks();
    t_long_frame();
    t_short_frame();
    check("R8 no change without load", silent_change, 0);
    check("R9 loads never together", both_high, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule